// File: doc/BRIEF.md
# PTP Event Frame Classifier

This block sits on a receive or transmit byte stream at the boundary between a MAC and a PHY. It follows each frame from its first byte (the one after the start-of-frame delimiter) through the Ethernet header, an optional single VLAN tag, and an optional IPv4/UDP or IPv6/UDP encapsulation. It then finds the precision time protocol header. For version-2 event messages it emits a single-cycle parallel record. The record holds a 3-bit type tag, the seconds and nanoseconds of the local time captured when the frame began, the 64-bit clock identity, the 16-bit source port number and the 16-bit sequence id. A downstream FIFO takes the record as is.

The link speed code sets how beats arrive. At 1000 Mb/s each beat carries a full byte. At 10 and 100 Mb/s each beat carries a nibble in `in_data[3:0]`, low nibble first. A path-direction input and a one-step enable let the block skip records for messages whose time is written into the frame on the fly.

The parser is a single state machine. Its states are PS_IDLE, PS_ETH, PS_VLAN, PS_IP4, PS_IP6, PS_UDP, PS_HDR and PS_SKIP.
- PS_IDLE goes to PS_ETH on the first byte of a frame.
- PS_ETH decides on its 14th byte, from the EtherType: 0x88F7 goes to PS_HDR, 0x0800 to PS_IP4, 0x86DD to PS_IP6, 0x8100 to PS_VLAN, and anything else to PS_SKIP.
- PS_VLAN decides on its 4th byte in the same way, except that a second 0x8100 goes to PS_SKIP.
- PS_IP4 goes to PS_UDP after IHL×4 bytes, and to PS_SKIP on a bad version, an IHL below 5, or a protocol other than 17.
- PS_IP6 goes to PS_UDP after 40 bytes, and to PS_SKIP if the next header is not 17.
- PS_UDP goes to PS_HDR after 8 bytes, and to PS_SKIP if the destination port is not 319.
- PS_HDR goes to PS_SKIP on a general message type, on a version other than 2, or after its 32nd byte.
- The end of a frame returns any state to PS_IDLE.

The beat aligner has three states, AL_IDLE, AL_FRAME and AL_HALF. AL_HALF means a low nibble is being held.

Top module: `ptp_event_classifier`

## Requirements
- R1: The message type is the low nibble of PTP header byte 0. Types 0 to 3 (Sync, Delay_Req, Pdelay_Req, Pdelay_Resp) produce a record. Types 4 to 15 produce none.
- R2: `rec_tag` encodes the type as 1 for Sync (0), 4 for Delay_Req (1), 2 for Pdelay_Req (2) and 3 for Pdelay_Resp (3). No other tag value is ever emitted.
- R3: With EtherType 0x88F7 the header starts after the 14-byte Ethernet header. One 0x8100 tag adds 4 bytes and its own EtherType field is used instead. A second tag, or any other EtherType, gives no record.
- R4: With EtherType 0x0800 the header follows IHL×4 IPv4 bytes plus 8 UDP bytes. With 0x86DD it follows 40 IPv6 bytes plus 8 UDP bytes. A record needs protocol or next header 17 and UDP destination port 319.
- R5: The clock identity is taken from header bytes 20 to 27, the source port from bytes 28 to 29 and the sequence id from bytes 30 to 31, all big-endian.
- R6: A header whose byte 1 low nibble is not 2 (for example version 1) produces no record.
- R7: A frame that ends before header byte 31 produces no record. A frame whose last byte is header byte 31 produces one.
- R8: When `path_is_tx` and `onestep_en` are both 1, Sync and Pdelay_Resp produce no record. Any other combination leaves them recorded.
- R9: `rec_sec` and `rec_ns` equal `time_sec` and `time_ns` as sampled on the clock edge that accepts the first beat of the frame.
- R10: Speed code 2 takes one byte per beat. Codes 0 and 1 take one nibble per beat in `in_data[3:0]`, low nibble first, with `in_last` on the final beat. Code 3 ignores all beats.
- R11: After reset `rec_valid` is 0. Each qualifying frame gives exactly one `rec_valid` pulse one cycle long, and the record fields hold between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_speed | input | 2 | 0 = 10 Mb/s, 1 = 100 Mb/s, 2 = 1000 Mb/s, 3 = off |
| path_is_tx | input | 1 | Block watches the transmit path |
| onestep_en | input | 1 | One-step operation enabled |
| time_sec | input | SEC_W | Free-running seconds |
| time_ns | input | NS_W | Free-running nanoseconds |
| in_valid | input | 1 | Beat valid |
| in_data | input | 8 | Byte, or nibble in bits 3:0 |
| in_last | input | 1 | Final beat of frame |
| rec_valid | output | 1 | Record strobe |
| rec_tag | output | 3 | Event type tag |
| rec_sec | output | SEC_W | Start-of-frame seconds |
| rec_ns | output | NS_W | Start-of-frame nanoseconds |
| rec_clock_id | output | 64 | Clock identity |
| rec_src_port | output | 16 | Source port number |
| rec_seq_id | output | 16 | Sequence id |

## Verification
The bench builds the block with its default parameters: 48-bit seconds, 32-bit nanoseconds and a 6-bit section counter. The 6-bit counter is wide enough for the longest IPv4 header, so every section boundary the parser can meet is within reach. The main sweep runs all 16 message types over L2, IPv4 and IPv6 framing, with and without a VLAN tag, and rotates among the byte and both nibble speeds. Further runs cover:
- every frame length around the end of the sequence id;
- all four one-step combinations;
- wrong protocol, port, version and EtherType;
- a double VLAN tag;
- the disabled speed code.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;

    typedef enum logic [1:0] {
        SPD_10M  = 2'd0,
        SPD_100M = 2'd1,
        SPD_1G   = 2'd2,
        SPD_OFF  = 2'd3
    } link_speed_e;

    typedef enum logic [1:0] {
        AL_IDLE,
        AL_FRAME,
        AL_HALF
    } align_state_e;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_ETH,
        PS_VLAN,
        PS_IP4,
        PS_IP6,
        PS_UDP,
        PS_HDR,
        PS_SKIP
    } parse_state_e;

    localparam logic [15:0] ET_PTP  = 16'h88F7;
    localparam logic [15:0] ET_IPV4 = 16'h0800;
    localparam logic [15:0] ET_IPV6 = 16'h86DD;
    localparam logic [15:0] ET_VLAN = 16'h8100;
    localparam logic [7:0]  PROTO_UDP = 8'd17;
    localparam logic [15:0] EVENT_PORT = 16'd319;

    // Event message type nibble to record tag
    function automatic logic [2:0] type_to_tag(input logic [3:0] mtype);
        logic [2:0] t;
        unique case (mtype)
            4'd0:    t = 3'd1;
            4'd1:    t = 3'd4;
            4'd2:    t = 3'd2;
            4'd3:    t = 3'd3;
            default: t = 3'd0;
        endcase
        return t;
    endfunction

    // Where to go once an EtherType has been seen
    function automatic parse_state_e etype_next(input logic [15:0] et, input logic vlan_ok);
        parse_state_e s;
        if (et == ET_PTP)
            s = PS_HDR;
        else if (et == ET_IPV4)
            s = PS_IP4;
        else if (et == ET_IPV6)
            s = PS_IP6;
        else if (et == ET_VLAN && vlan_ok)
            s = PS_VLAN;
        else
            s = PS_SKIP;
        return s;
    endfunction

endpackage

// File: rtl/ptpc_beat_align.sv
module ptpc_beat_align
    import ptpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] link_speed,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       frame_start,
    output logic       b_valid,
    output logic [7:0] b_data,
    output logic       b_eof
);

    align_state_e st_q, st_d;
    link_speed_e  spd;
    logic         accept;
    logic [3:0]   lo_q;

    assign spd         = link_speed_e'(link_speed);
    assign accept      = in_valid && (spd != SPD_OFF);
    assign frame_start = accept && (st_q == AL_IDLE);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            AL_IDLE, AL_FRAME: begin
                if (accept) begin
                    if (in_last)
                        st_d = AL_IDLE;
                    else if (spd == SPD_1G)
                        st_d = AL_FRAME;
                    else
                        st_d = AL_HALF;
                end
            end
            AL_HALF: begin
                if (accept)
                    st_d = in_last ? AL_IDLE : AL_FRAME;
            end
            default: st_d = AL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= AL_IDLE;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_valid <= 1'b0;
            b_eof   <= 1'b0;
            b_data  <= '0;
            lo_q    <= '0;
        end else begin
            b_valid <= accept && ((st_q == AL_HALF) || (spd == SPD_1G));
            b_eof   <= accept && in_last;
            if (accept)
                b_data <= (st_q == AL_HALF) ? {in_data[3:0], lo_q} : in_data;
            if (accept && st_q != AL_HALF)
                lo_q <= in_data[3:0];
        end
    end

    // R10: a byte-mode beat becomes a byte on the next cycle
    a_r10_gig_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && spd == SPD_1G && st_q != AL_HALF) |=> (b_valid && b_data == $past(in_data)));

    // R10: the first nibble of a byte yields no byte
    a_r10_low_nibble_held: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (spd == SPD_100M || spd == SPD_10M) && st_q != AL_HALF) |=> !b_valid);

    // R10: the reserved speed code passes nothing
    a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (spd == SPD_OFF) |=> (!b_valid && !b_eof));

endmodule

// File: rtl/ptpc_hdr_parser.sv
module ptpc_hdr_parser
    import ptpc_pkg::*;
#(
    parameter int SEC_W = 48,
    parameter int NS_W  = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             b_valid,
    input  logic [7:0]       b_data,
    input  logic             b_eof,
    input  logic             path_is_tx,
    input  logic             onestep_en,
    input  logic [SEC_W-1:0] ts_sec,
    input  logic [NS_W-1:0]  ts_ns,
    output logic             rec_valid,
    output logic [2:0]       rec_tag,
    output logic [SEC_W-1:0] rec_sec,
    output logic [NS_W-1:0]  rec_ns,
    output logic [63:0]      rec_clock_id,
    output logic [15:0]      rec_src_port,
    output logic [15:0]      rec_seq_id
);

    localparam logic [CNT_W-1:0] ETH_LAST  = CNT_W'(13);
    localparam logic [CNT_W-1:0] VLAN_LAST = CNT_W'(3);
    localparam logic [CNT_W-1:0] IP4_PROTO = CNT_W'(9);
    localparam logic [CNT_W-1:0] IP6_NEXT  = CNT_W'(6);
    localparam logic [CNT_W-1:0] IP6_LAST  = CNT_W'(39);
    localparam logic [CNT_W-1:0] UDP_DPORT = CNT_W'(3);
    localparam logic [CNT_W-1:0] UDP_LAST  = CNT_W'(7);
    localparam logic [CNT_W-1:0] CLK_FIRST = CNT_W'(20);
    localparam logic [CNT_W-1:0] CLK_LAST  = CNT_W'(27);
    localparam logic [CNT_W-1:0] PORT_LO   = CNT_W'(28);
    localparam logic [CNT_W-1:0] PORT_HI   = CNT_W'(29);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(31);

    parse_state_e   st_q, st_d;
    logic [CNT_W-1:0] sc_q;
    logic [CNT_W-1:0] ip4_end_q;
    logic [7:0]     prev_q;
    logic [3:0]     type_q;
    logic [63:0]    clk_q;
    logic [15:0]    port_q;
    logic           suppress;
    logic           emit;

    assign suppress = path_is_tx && onestep_en && (type_q == 4'd0 || type_q == 4'd3);
    assign emit     = b_valid && (st_q == PS_HDR) && (sc_q == HDR_LAST) && !suppress;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (b_valid) begin
            unique case (st_q)
                PS_IDLE: st_d = PS_ETH;
                PS_ETH: begin
                    if (sc_q == ETH_LAST)
                        st_d = etype_next({prev_q, b_data}, 1'b1);
                end
                PS_VLAN: begin
                    if (sc_q == VLAN_LAST)
                        st_d = etype_next({prev_q, b_data}, 1'b0);
                end
                PS_IP4: begin
                    if (sc_q == '0 && (b_data[7:4] != 4'd4 || b_data[3:0] < 4'd5))
                        st_d = PS_SKIP;
                    else if (sc_q == IP4_PROTO && b_data != PROTO_UDP)
                        st_d = PS_SKIP;
                    else if (sc_q != '0 && sc_q == ip4_end_q)
                        st_d = PS_UDP;
                end
                PS_IP6: begin
                    if (sc_q == IP6_NEXT && b_data != PROTO_UDP)
                        st_d = PS_SKIP;
                    else if (sc_q == IP6_LAST)
                        st_d = PS_UDP;
                end
                PS_UDP: begin
                    if (sc_q == UDP_DPORT && {prev_q, b_data} != EVENT_PORT)
                        st_d = PS_SKIP;
                    else if (sc_q == UDP_LAST)
                        st_d = PS_HDR;
                end
                PS_HDR: begin
                    if (sc_q == '0 && b_data[3:0] >= 4'd4)
                        st_d = PS_SKIP;
                    else if (sc_q == CNT_W'(1) && b_data[3:0] != 4'd2)
                        st_d = PS_SKIP;
                    else if (sc_q == HDR_LAST)
                        st_d = PS_SKIP;
                end
                PS_SKIP: st_d = PS_SKIP;
                default: st_d = PS_IDLE;
            endcase
        end
        if (b_eof)
            st_d = PS_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= PS_IDLE;
        else
            st_q <= st_d;
    end

    // Section counter and field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q      <= '0;
            ip4_end_q <= '0;
            prev_q    <= '0;
            type_q    <= '0;
            clk_q     <= '0;
            port_q    <= '0;
        end else if (b_valid) begin
            prev_q <= b_data;
            if (st_d != st_q)
                sc_q <= (st_q == PS_IDLE) ? CNT_W'(1) : '0;
            else
                sc_q <= sc_q + CNT_W'(1);
            if (st_q == PS_IP4 && sc_q == '0)
                ip4_end_q <= CNT_W'({b_data[3:0], 2'b00} - 6'd1);
            if (st_q == PS_HDR) begin
                if (sc_q == '0)
                    type_q <= b_data[3:0];
                if (sc_q >= CLK_FIRST && sc_q <= CLK_LAST)
                    clk_q <= {clk_q[55:0], b_data};
                if (sc_q == PORT_LO || sc_q == PORT_HI)
                    port_q <= {port_q[7:0], b_data};
            end
        end
    end

    // Record outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid    <= 1'b0;
            rec_tag      <= '0;
            rec_sec      <= '0;
            rec_ns       <= '0;
            rec_clock_id <= '0;
            rec_src_port <= '0;
            rec_seq_id   <= '0;
        end else begin
            rec_valid <= emit;
            if (emit) begin
                rec_tag      <= type_to_tag(type_q);
                rec_sec      <= ts_sec;
                rec_ns       <= ts_ns;
                rec_clock_id <= clk_q;
                rec_src_port <= port_q;
                rec_seq_id   <= {prev_q, b_data};
            end
        end
    end

    // R11: a record strobe lasts one cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> !rec_valid);

    // R2: only the four defined tags appear
    a_r2_tag_legal: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_tag == 3'd1 || rec_tag == 3'd2 || rec_tag == 3'd3 || rec_tag == 3'd4));

    // R8: one-step transmit never records Sync or Pdelay_Resp
    a_r8_onestep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> !($past(path_is_tx && onestep_en) && (rec_tag == 3'd1 || rec_tag == 3'd3)));

    // R7: a record follows only a byte seen inside the PTP header
    a_r7_from_header: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> ($past(st_q) == PS_HDR && $past(b_valid)));

endmodule

// File: rtl/ptp_event_classifier.sv
module ptp_event_classifier
    import ptpc_pkg::*;
#(
    parameter int SEC_W = 48,
    parameter int NS_W  = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       link_speed,
    input  logic             path_is_tx,
    input  logic             onestep_en,
    input  logic [SEC_W-1:0] time_sec,
    input  logic [NS_W-1:0]  time_ns,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             rec_valid,
    output logic [2:0]       rec_tag,
    output logic [SEC_W-1:0] rec_sec,
    output logic [NS_W-1:0]  rec_ns,
    output logic [63:0]      rec_clock_id,
    output logic [15:0]      rec_src_port,
    output logic [15:0]      rec_seq_id
);

    logic             frame_start;
    logic             b_valid;
    logic [7:0]       b_data;
    logic             b_eof;
    logic [SEC_W-1:0] ts_sec_q;
    logic [NS_W-1:0]  ts_ns_q;

    ptpc_beat_align u_align (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_speed  (link_speed),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_last     (in_last),
        .frame_start (frame_start),
        .b_valid     (b_valid),
        .b_data      (b_data),
        .b_eof       (b_eof)
    );

    // Start-of-frame time capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_sec_q <= '0;
            ts_ns_q  <= '0;
        end else if (frame_start) begin
            ts_sec_q <= time_sec;
            ts_ns_q  <= time_ns;
        end
    end

    ptpc_hdr_parser #(
        .SEC_W (SEC_W),
        .NS_W  (NS_W),
        .CNT_W (CNT_W)
    ) u_parser (
        .clk          (clk),
        .rst_n        (rst_n),
        .b_valid      (b_valid),
        .b_data       (b_data),
        .b_eof        (b_eof),
        .path_is_tx   (path_is_tx),
        .onestep_en   (onestep_en),
        .ts_sec       (ts_sec_q),
        .ts_ns        (ts_ns_q),
        .rec_valid    (rec_valid),
        .rec_tag      (rec_tag),
        .rec_sec      (rec_sec),
        .rec_ns       (rec_ns),
        .rec_clock_id (rec_clock_id),
        .rec_src_port (rec_src_port),
        .rec_seq_id   (rec_seq_id)
    );

    // R9: the captured time stays put while no frame starts
    a_r9_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(ts_sec_q) && $stable(ts_ns_q));

endmodule

// File: tb/ptp_event_classifier_test.sv
`timescale 1ns/1ps
module ptp_event_classifier_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  link_speed = 2'd2;
    logic        path_is_tx = 1'b0;
    logic        onestep_en = 1'b0;
    logic [47:0] time_sec;
    logic [31:0] time_ns;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        rec_valid;
    logic [2:0]  rec_tag;
    logic [47:0] rec_sec;
    logic [31:0] rec_ns;
    logic [63:0] rec_clock_id;
    logic [15:0] rec_src_port;
    logic [15:0] rec_seq_id;

    int unsigned cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign time_sec = 48'(100 + cyc / 64);
    assign time_ns  = 32'((cyc % 64) * 20);

    ptp_event_classifier uut (
        .clk(clk), .rst_n(rst_n), .link_speed(link_speed),
        .path_is_tx(path_is_tx), .onestep_en(onestep_en),
        .time_sec(time_sec), .time_ns(time_ns),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .rec_valid(rec_valid), .rec_tag(rec_tag), .rec_sec(rec_sec), .rec_ns(rec_ns),
        .rec_clock_id(rec_clock_id), .rec_src_port(rec_src_port), .rec_seq_id(rec_seq_id)
    );

    // Record monitor
    int n_got = 0;
    logic [2:0]  g_tag;
    logic [63:0] g_clk;
    logic [15:0] g_port, g_seq;
    logic [47:0] g_sec;
    logic [31:0] g_ns;
    always @(negedge clk) begin
        if (rec_valid) begin
            n_got  = n_got + 1;
            g_tag  = rec_tag;
            g_clk  = rec_clock_id;
            g_port = rec_src_port;
            g_seq  = rec_seq_id;
            g_sec  = rec_sec;
            g_ns   = rec_ns;
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    logic [7:0] fb [0:199];
    int flen = 0;
    int unsigned start_cyc = 0;

    task automatic put(input logic [7:0] b);
        fb[flen] = b;
        flen++;
    endtask

    function automatic logic [63:0] clk_of(input int n);
        return {8'hC0, 8'(n), 16'hBEEF, 32'(n) * 32'h01010101 + 32'd5};
    endfunction
    function automatic logic [15:0] port_of(input int n);
        return 16'(n * 3 + 2);
    endfunction
    function automatic logic [15:0] seq_of(input int n);
        return 16'(n * 7 + 1);
    endfunction
    function automatic logic [2:0] tag_of(input int mt);
        case (mt)
            0: return 3'd1;
            1: return 3'd4;
            2: return 3'd2;
            3: return 3'd3;
            default: return 3'd0;
        endcase
    endfunction

    // encap: 0 L2, 1 IPv4/UDP, 2 IPv6/UDP, 3 unknown EtherType, 4 nested VLAN
    task automatic build(input int encap, input int vlan, input int mt, input int ver,
                         input int proto, input int dport, input int n);
        logic [63:0] c;
        int ihl;
        flen = 0;
        c = clk_of(n);
        for (int i = 0; i < 12; i++) put(8'(8'h10 + i));
        if (vlan != 0) begin put(8'h81); put(8'h00); put(8'h20); put(8'h05); end
        case (encap)
            0: begin put(8'h88); put(8'hF7); end
            1: begin put(8'h08); put(8'h00); end
            2: begin put(8'h86); put(8'hDD); end
            3: begin put(8'h08); put(8'h06); end
            default: begin put(8'h81); put(8'h00); put(8'h00); put(8'h07);
                           put(8'h88); put(8'hF7); end
        endcase
        if (encap == 1) begin
            ihl = (vlan != 0) ? 6 : 5;
            put(8'(8'h40 | ihl));
            for (int k = 1; k < ihl * 4; k++) put((k == 9) ? 8'(proto) : 8'h00);
        end
        if (encap == 2) begin
            for (int k = 0; k < 40; k++)
                put((k == 0) ? 8'h60 : ((k == 6) ? 8'(proto) : 8'h00));
        end
        if (encap == 1 || encap == 2) begin
            put(8'h04); put(8'hD2); put(8'(dport >> 8)); put(8'(dport));
            put(8'h00); put(8'h40); put(8'h00); put(8'h00);
        end
        put(8'(8'h10 | mt));
        put(8'(ver));
        for (int k = 2; k < 20; k++) put(8'hEE);
        for (int k = 7; k >= 0; k--) put(c[k*8 +: 8]);
        put(port_of(n)[15:8]); put(port_of(n)[7:0]);
        put(seq_of(n)[15:8]); put(seq_of(n)[7:0]);
        for (int k = 0; k < 8; k++) put(8'h55);
    endtask

    task automatic send(input int spd);
        n_got = 0;
        link_speed = 2'(spd);
        for (int i = 0; i < flen; i++) begin
            if (spd == 2 || spd == 3) begin
                @(negedge clk);
                in_valid = 1'b1; in_data = fb[i]; in_last = (i == flen - 1);
                if (i == 0) start_cyc = cyc;
            end else begin
                @(negedge clk);
                in_valid = 1'b1; in_data = {4'h0, fb[i][3:0]}; in_last = 1'b0;
                if (i == 0) start_cyc = cyc;
                @(negedge clk);
                in_valid = 1'b1; in_data = {4'h0, fb[i][7:4]}; in_last = (i == flen - 1);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_rec(input string req, input bit exp, input int mt, input int n);
        chk({req, " record count"}, 64'(n_got), exp ? 64'd1 : 64'd0);
        if (exp && n_got == 1) begin
            chk("R2 tag", 64'(g_tag), 64'(tag_of(mt)));
            chk("R5 clock id", g_clk, clk_of(n));
            chk("R5 source port", 64'(g_port), 64'(port_of(n)));
            chk("R5 sequence id", 64'(g_seq), 64'(seq_of(n)));
            chk("R9 seconds", 64'(g_sec), 64'(100 + start_cyc / 64));
            chk("R9 nanoseconds", 64'(g_ns), 64'((start_cyc % 64) * 20));
        end
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        bit e;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 rec_valid after reset", 64'(rec_valid), 64'd0);
        chk("R11 rec_tag after reset", 64'(rec_tag), 64'd0);

        // R1 R3 R4 R10 sweep: framings x VLAN x all message types x speeds
        n = 0;
        for (int enc = 0; enc < 3; enc++)
            for (int v = 0; v < 2; v++)
                for (int mt = 0; mt < 16; mt++) begin
                    build(enc, v, mt, 2, 17, 319, n);
                    send((n % 3 == 0) ? 1 : ((n % 3 == 1) ? 2 : 0));
                    expect_rec("R1 R3 R4 R10 R11", mt < 4, mt, n);
                    n++;
                end

        // R7 truncation around the end of the sequence id (header ends at length 46)
        for (int len = 40; len <= 50; len++) begin
            build(0, 0, 1, 2, 17, 319, n);
            flen = len;
            send(2);
            expect_rec("R7 truncation", len >= 46, 1, n);
            n++;
        end

        // R8 one-step combinations
        for (int tx = 0; tx < 2; tx++)
            for (int os = 0; os < 2; os++)
                for (int mt = 0; mt < 4; mt++) begin
                    path_is_tx = 1'(tx); onestep_en = 1'(os);
                    build(1, 0, mt, 2, 17, 319, n);
                    send(2);
                    e = !(tx == 1 && os == 1 && (mt == 0 || mt == 3));
                    expect_rec("R8 one-step", e, mt, n);
                    n++;
                end
        path_is_tx = 1'b0; onestep_en = 1'b0;

        // R6 version 1
        build(0, 0, 0, 1, 17, 319, n); send(2); expect_rec("R6 version 1", 1'b0, 0, n); n++;
        build(2, 1, 3, 1, 17, 319, n); send(1); expect_rec("R6 version 1 ipv6", 1'b0, 3, n); n++;
        // R4 wrong protocol / port
        build(1, 0, 0, 2, 6, 319, n); send(2); expect_rec("R4 protocol 6", 1'b0, 0, n); n++;
        build(2, 0, 0, 2, 6, 319, n); send(2); expect_rec("R4 next header 6", 1'b0, 0, n); n++;
        build(1, 1, 2, 2, 17, 320, n); send(2); expect_rec("R4 port 320", 1'b0, 2, n); n++;
        // R3 unknown EtherType and nested VLAN
        build(3, 0, 0, 2, 17, 319, n); send(2); expect_rec("R3 unknown ethertype", 1'b0, 0, n); n++;
        build(4, 1, 0, 2, 17, 319, n); send(2); expect_rec("R3 second vlan", 1'b0, 0, n); n++;
        // R10 reserved speed ignores the frame; a good frame afterwards still works
        build(0, 0, 0, 2, 17, 319, n); send(3); expect_rec("R10 speed off", 1'b0, 0, n); n++;
        build(0, 1, 2, 2, 17, 319, n); send(0); expect_rec("R10 10M after off", 1'b1, 2, n); n++;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule